// File: doc/BRIEF.md
# Parallel Handshake Port with Edge Latches

This block joins a host to a neighbouring processor over a 16-bit parallel link. Each direction has two handshake lines: "done" (the sender has finished with the last word) and "ready" (new data is waiting). The two lines coming from the peer are asynchronous. Each one is synchronised and then edge-detected. A rising edge sets a sticky latch, and the latch stays set until the host clears it with its own clear strobe. An interrupt request is raised while a latch is set and its enable is on.

The host sees a few simple strobes. One writes the outgoing data word. One writes a 6-bit control register, which drives the two outgoing handshake lines, selects loopback and holds the two interrupt enables. Two strobes clear the latches, and a reset command loads the control register while clearing both latches. A status word returns the synchronised incoming data and both latch states. In loopback mode each outgoing handshake line feeds the matching incoming latch in place of the peer's line. This lets the host exercise the handshake without a peer.

Top module: `hs_parallel_port`

## Requirements
- R1: After rst_n is released, peer_data_out, both outgoing handshake lines, irq and both latch bits of status_word all read 0.
- R2: A rising edge on peer_done_in sets the done latch (status_word bit 17) within 3 clocks. A line held high does not set the latch again after it has been cleared.
- R3: A rising edge on peer_ready_in sets the ready latch (status_word bit 16) within 3 clocks.
- R4: clr_done clears only the done latch, and clr_ready clears only the ready latch.
- R5: If a rising edge and the clear strobe for the same latch occur in the same cycle, the latch ends up set.
- R6: A ctrl_wr strobe loads ctrl_wdata. Bit 0 drives peer_ready_out, bit 1 drives peer_done_out, bit 2 selects loopback, bit 3 is spare, bit 4 enables the ready interrupt and bit 5 enables the done interrupt.
- R7: With loopback on, a rise of peer_done_out sets the done latch and a rise of peer_ready_out sets the ready latch. The peer's handshake inputs are ignored.
- R8: irq is 1 exactly when (done latch AND bit 5) OR (ready latch AND bit 4).
- R9: status_word is {done latch, ready latch, peer_data_in}. The data field shows a stable input value within 3 clocks.
- R10: peer_data_out takes data_wdata one clock after data_wr and holds otherwise.
- R11: rst_cmd loads the control register from ctrl_wdata and clears both latches, taking priority over any edge in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_wr | input | 1 | Load outgoing data register |
| data_wdata | input | 16 | Outgoing data value |
| ctrl_wr | input | 1 | Load control register |
| rst_cmd | input | 1 | Load control register and clear both latches |
| ctrl_wdata | input | 6 | Control register value |
| clr_done | input | 1 | Clear done latch |
| clr_ready | input | 1 | Clear ready latch |
| peer_data_in | input | 16 | Data from peer (asynchronous) |
| peer_done_in | input | 1 | Done line from peer (asynchronous) |
| peer_ready_in | input | 1 | Ready line from peer (asynchronous) |
| peer_data_out | output | 16 | Data to peer |
| peer_done_out | output | 1 | Done line to peer |
| peer_ready_out | output | 1 | Ready line to peer |
| irq | output | 1 | Interrupt request |
| status_word | output | 18 | {done latch, ready latch, synchronised peer data} |

## Verification
The hardest case to reach is a set edge and a clear strobe for the same latch in the same clock. Through the external lines that edge lands at a point fixed by the synchroniser depth. The bench uses loopback instead: a control write raises the outgoing ready line, and the edge appears in the very next cycle. The bench asserts clr_ready in exactly that cycle. It then checks that the latch holds, and that a later lone clear does empty it.

// File: rtl/hsport_pkg.sv
package hsport_pkg;
  localparam int CTRL_W = 6;

  typedef struct packed {
    logic en_done;
    logic en_ready;
    logic spare;
    logic loop;
    logic drv_done;
    logic drv_ready;
  } ctrl_t;

  function automatic logic irq_of(ctrl_t c, logic done_lat, logic ready_lat);
    return (done_lat & c.en_done) | (ready_lat & c.en_ready);
  endfunction

  function automatic logic latch_next(logic cur, logic rise, logic clr, logic clr_all);
    if (clr_all) return 1'b0;
    if (rise) return 1'b1;
    if (clr) return 1'b0;
    return cur;
  endfunction
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int W = 18,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= async_in;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= '0;
      else        stage_q[g] <= stage_q[g-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/hs_edge_latch.sv
module hs_edge_latch
  import hsport_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  input  logic clr,
  input  logic clr_all,
  output logic rise,
  output logic lat
);
  logic prev_q;

  assign rise = src & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      lat    <= 1'b0;
    end else begin
      prev_q <= src;
      lat    <= latch_next(lat, rise, clr, clr_all);
    end
  end

  // R5
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !clr_all) |=> lat);
  // R4
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !rise) |=> !lat);
  // R11
  cmd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> !lat);
  // R2
  latch_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise && !clr && !clr_all) |=> $stable(lat));
endmodule

// File: rtl/hs_parallel_port.sv
module hs_parallel_port
  import hsport_pkg::*;
#(
  parameter int DW = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                data_wr,
  input  logic [DW-1:0]       data_wdata,
  input  logic                ctrl_wr,
  input  logic                rst_cmd,
  input  logic [CTRL_W-1:0]   ctrl_wdata,
  input  logic                clr_done,
  input  logic                clr_ready,
  input  logic [DW-1:0]       peer_data_in,
  input  logic                peer_done_in,
  input  logic                peer_ready_in,
  output logic [DW-1:0]       peer_data_out,
  output logic                peer_done_out,
  output logic                peer_ready_out,
  output logic                irq,
  output logic [DW+1:0]       status_word
);
  localparam int SW = DW + 2;

  ctrl_t          ctrl_q;
  logic [SW-1:0]  sync_bus;
  logic [DW-1:0]  data_sync;
  logic           done_sync, ready_sync;
  logic           done_src, ready_src;
  logic           done_rise, ready_rise;
  logic           done_lat, ready_lat;

  hs_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({peer_done_in, peer_ready_in, peer_data_in}),
    .sync_out(sync_bus)
  );
  assign {done_sync, ready_sync, data_sync} = sync_bus;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ctrl_q <= '0;
    else if (ctrl_wr || rst_cmd) ctrl_q <= ctrl_t'(ctrl_wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       peer_data_out <= '0;
    else if (data_wr) peer_data_out <= data_wdata;
  end

  assign peer_done_out  = ctrl_q.drv_done;
  assign peer_ready_out = ctrl_q.drv_ready;
  assign done_src  = ctrl_q.loop ? ctrl_q.drv_done  : done_sync;
  assign ready_src = ctrl_q.loop ? ctrl_q.drv_ready : ready_sync;

  hs_edge_latch u_done_latch (
    .clk(clk), .rst_n(rst_n), .src(done_src), .clr(clr_done),
    .clr_all(rst_cmd), .rise(done_rise), .lat(done_lat)
  );

  hs_edge_latch u_ready_latch (
    .clk(clk), .rst_n(rst_n), .src(ready_src), .clr(clr_ready),
    .clr_all(rst_cmd), .rise(ready_rise), .lat(ready_lat)
  );

  assign irq         = irq_of(ctrl_q, done_lat, ready_lat);
  assign status_word = {done_lat, ready_lat, data_sync};

  // R6
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr || rst_cmd) |=> (ctrl_q == $past(ctrl_wdata)));
  // R10
  data_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> (peer_data_out == $past(data_wdata)));
  // R10
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr |=> $stable(peer_data_out));
  // R2
  done_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_rise && !rst_cmd) |=> status_word[DW+1]);
  // R3
  ready_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_rise && !rst_cmd) |=> status_word[DW]);
endmodule

// File: tb/test_hs_parallel_port.sv
`timescale 1ns/1ps
module test_hs_parallel_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        data_wr = 0, ctrl_wr = 0, rst_cmd = 0, clr_done = 0, clr_ready = 0;
  logic [15:0] data_wdata = '0, peer_data_in = '0;
  logic [5:0]  ctrl_wdata = '0;
  logic        peer_done_in = 0, peer_ready_in = 0;
  logic [15:0] peer_data_out;
  logic        peer_done_out, peer_ready_out, irq;
  logic [17:0] status_word;
  int          n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  hs_parallel_port i_hs_parallel_port (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .data_wdata(data_wdata),
    .ctrl_wr(ctrl_wr), .rst_cmd(rst_cmd), .ctrl_wdata(ctrl_wdata),
    .clr_done(clr_done), .clr_ready(clr_ready), .peer_data_in(peer_data_in),
    .peer_done_in(peer_done_in), .peer_ready_in(peer_ready_in),
    .peer_data_out(peer_data_out), .peer_done_out(peer_done_out),
    .peer_ready_out(peer_ready_out), .irq(irq), .status_word(status_word)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_ctrl(logic [5:0] v);
    ctrl_wdata = v; ctrl_wr = 1; tick(1); ctrl_wr = 0; tick(1);
  endtask

  task automatic pulse_clr(logic d, logic r);
    clr_done = d; clr_ready = r; tick(1); clr_done = 0; clr_ready = 0; tick(1);
  endtask

  task automatic t_reset;
    chk("R1 data out", peer_data_out, 0);
    chk("R1 lines", {peer_done_out, peer_ready_out, irq}, 0);
    chk("R1 latches", status_word[17:16], 0);
  endtask

  task automatic t_data_out;
    data_wdata = 16'hA5C3; data_wr = 1; tick(1); data_wr = 0;
    chk("R10 load", peer_data_out, 16'hA5C3);
    data_wdata = 16'h1234; tick(3);
    chk("R10 hold", peer_data_out, 16'hA5C3);
  endtask

  task automatic t_ctrl_lines;
    write_ctrl(6'b000011);
    chk("R6 both lines", {peer_done_out, peer_ready_out}, 2'b11);
    write_ctrl(6'b000010);
    chk("R6 done only", {peer_done_out, peer_ready_out}, 2'b10);
    write_ctrl(6'b000000);
  endtask

  task automatic t_peer_done;
    peer_done_in = 1; tick(4);
    chk("R2 done set", status_word[17:16], 2'b10);
    chk("R8 no enable", irq, 0);
    pulse_clr(1, 0); tick(3);
    chk("R2 level not resetting", status_word[17], 0);
    peer_done_in = 0; tick(3);
  endtask

  task automatic t_peer_ready_irq;
    write_ctrl(6'b010000);
    peer_ready_in = 1; tick(4); peer_ready_in = 0;
    chk("R3 ready set", status_word[17:16], 2'b01);
    chk("R8 ready irq", irq, 1);
    write_ctrl(6'b100000);
    chk("R8 wrong enable", irq, 0);
    peer_done_in = 1; tick(4); peer_done_in = 0; tick(3);
    chk("R8 done irq", irq, 1);
    pulse_clr(0, 1);
    chk("R4 ready only", status_word[17:16], 2'b10);
    pulse_clr(1, 0);
    chk("R4 done cleared", status_word[17:16], 2'b00);
    chk("R8 irq drop", irq, 0);
    write_ctrl(6'b000000);
  endtask

  task automatic t_set_wins;
    write_ctrl(6'b000100);
    ctrl_wdata = 6'b000101; ctrl_wr = 1; tick(1);
    ctrl_wr = 0; clr_ready = 1; tick(1); clr_ready = 0;
    chk("R5 set beats clear", status_word[16], 1);
    pulse_clr(0, 1);
    chk("R5 later clear", status_word[16], 0);
    write_ctrl(6'b000100);
  endtask

  task automatic t_loopback;
    write_ctrl(6'b000110); tick(1);
    chk("R7 done loop", status_word[17:16], 2'b10);
    write_ctrl(6'b000111); tick(1);
    chk("R7 ready loop", status_word[17:16], 2'b11);
    pulse_clr(1, 1);
    peer_done_in = 1; peer_ready_in = 1; tick(5);
    chk("R7 peer ignored", status_word[17:16], 2'b00);
    peer_done_in = 0; peer_ready_in = 0; tick(3);
    write_ctrl(6'b000000); pulse_clr(1, 1);
  endtask

  task automatic t_status_data;
    peer_data_in = 16'h3C5A; tick(3);
    chk("R9 data field", status_word[15:0], 16'h3C5A);
    peer_data_in = 16'hC3A5; tick(3);
    chk("R9 data field 2", status_word[15:0], 16'hC3A5);
  endtask

  task automatic t_rst_cmd;
    write_ctrl(6'b000110); tick(1);
    chk("R11 precondition", status_word[17], 1);
    ctrl_wdata = 6'b100001; rst_cmd = 1; tick(1); rst_cmd = 0;
    chk("R11 latches clear", status_word[17:16], 0);
    chk("R11 ctrl loaded", {peer_done_out, peer_ready_out}, 2'b01);
  endtask

  initial begin
    tick(3); rst_n = 1; tick(2);
    t_reset();
    t_data_out();
    t_ctrl_lines();
    t_peer_done();
    t_peer_ready_irq();
    t_set_wins();
    t_loopback();
    t_status_data();
    t_rst_cmd();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule